// File: doc/BRIEF.md
# Fast GPIO Output and Direction Register Block

This block gives software single-cycle control over 30 general-purpose pins through a plain 32-bit memory-mapped bus. It holds a pin output value register and a pin output-enable register. Each of the two has three alias addresses that set, clear or invert only the bits written as 1, so a pin can be changed with one store and without a read-modify-write sequence.

Every pin also has a control word with a 5-bit function-select field. When that field holds 5, the pad output and pad output-enable of the pin come from this block's registers. For any other value another function owns the pin, and the pad follows the alternate-function inputs. Pad input levels pass through a two-flop synchroniser and can be read back through an input register.

The bus window is 12 bits wide. Address bit 11 clear selects the fast register group and bit 11 set selects the per-pin control bank. Reads are combinational in the cycle the access is presented, and writes take effect at the clock edge that samples them.

Top module: `gpio_fast_io`

## Requirements
- R1: After reset the output and output-enable registers read 0, every function-select field reads 31, and so every pad follows `alt_out`/`alt_oe`.
- R2: A write to the plain output address 0x010 or the plain output-enable address 0x020 replaces the whole register. Bits 31 and 30 of every register read as 0.
- R3: A write to the SET alias (output 0x014, output-enable 0x024) forces the bits written as 1 to 1 and leaves the other bits unchanged.
- R4: A write to the CLR alias (output 0x018, output-enable 0x028) forces the bits written as 1 to 0 and leaves the other bits unchanged.
- R5: A write to the XOR alias (output 0x01C, output-enable 0x02C) inverts the bits written as 1 and leaves the other bits unchanged.
- R6: A read of any alias address returns the current value of its base register. Any other fast-group offset reads 0, and a write to it changes no register.
- R7: The input register at 0x004 returns `pad_in` delayed through two flops. A level applied before clock edge k is first read after edge k+1.
- R8: The control word of pin n sits at 0x800 + 8*n + 4. Its bits [4:0] hold the function select and read back, and its other bits read 0. The first word of each pin pair, and the pair of any pin index of 30 or above, read 0 and ignore writes.
- R9: A pin whose function select equals 5 drives `pad_out`/`pad_oe` from the output and output-enable registers. Any other value passes `alt_out`/`alt_oe` through for that pin.
- R10: A register write changes `pad_out`/`pad_oe` in the cycle right after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 when not reading |
| pad_in | input | 30 | Asynchronous pad input levels |
| alt_out | input | 30 | Pad output from the alternate function |
| alt_oe | input | 30 | Pad output enable from the alternate function |
| pad_out | output | 30 | Pad output level |
| pad_oe | output | 30 | Pad output enable |

## Verification
The alias operations are driven with mask patterns that overlap the register's current ones and zeros. This separates a correct SET, CLR or XOR from a plain write, from an operation with the wrong polarity and from one that reaches bits outside the mask. All-ones writes show whether the two top bits are dropped. Different function selects are tried on neighbouring pins while `alt_out` carries a pattern that differs from the registers, so the pad shows which source was chosen for each pin. Input reads are timed edge by edge, which shows whether the synchroniser has too few or too many stages.

// File: rtl/gpio_fast_pkg.sv
package gpio_fast_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned FSEL_W     = 5;
  localparam int unsigned FSEL_FAST  = 5;
  localparam int unsigned FSEL_RESET = 31;

  typedef enum logic [1:0] {
    ALIAS_WRITE = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLR   = 2'd2,
    ALIAS_XOR   = 2'd3
  } alias_op_e;

  typedef enum logic [2:0] {
    RSRC_NONE = 3'd0,
    RSRC_IN   = 3'd1,
    RSRC_OUT  = 3'd2,
    RSRC_OE   = 3'd3,
    RSRC_CTRL = 3'd4
  } rd_src_e;

  function automatic logic [DATA_W-1:0] alias_next(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd,
    input alias_op_e         op
  );
    case (op)
      ALIAS_SET: return cur | wd;
      ALIAS_CLR: return cur & ~wd;
      ALIAS_XOR: return cur ^ wd;
      default:   return wd;
    endcase
  endfunction

endpackage

// File: rtl/gpio_fast_sync.sv
module gpio_fast_sync #(
  parameter int unsigned WIDTH  = 30,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_fast_decode.sv
module gpio_fast_decode
  import gpio_fast_pkg::*;
#(
  parameter int unsigned NPINS = 30
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              out_wr,
  output logic              oe_wr,
  output alias_op_e         op,
  output logic              ctrl_wr,
  output rd_src_e           rd_src,
  output logic [ADDR_W-4:0] pin_idx
);

  localparam int unsigned PIN_W = ADDR_W - 3;

  logic       fast_region;
  logic       fast_row;
  logic [1:0] group;
  logic       ctrl_ok;
  logic [1:0] unused_byte_lane;

  assign unused_byte_lane = bus_addr[1:0];
  assign fast_region = ~bus_addr[ADDR_W-1];
  assign fast_row    = fast_region && (bus_addr[ADDR_W-2:6] == '0);
  assign group       = bus_addr[5:4];
  assign op          = alias_op_e'(bus_addr[3:2]);
  assign pin_idx     = bus_addr[ADDR_W-2:3];
  assign ctrl_ok     = bus_addr[ADDR_W-1] && bus_addr[2] &&
                       (pin_idx < PIN_W'(NPINS));

  assign out_wr  = bus_sel && bus_wr && fast_row && (group == 2'd1);
  assign oe_wr   = bus_sel && bus_wr && fast_row && (group == 2'd2);
  assign ctrl_wr = bus_sel && bus_wr && ctrl_ok;

  always_comb begin
    rd_src = RSRC_NONE;
    if (bus_sel && !bus_wr) begin
      if (ctrl_ok) begin
        rd_src = RSRC_CTRL;
      end else if (fast_row) begin
        case (group)
          2'd0:    rd_src = (bus_addr[3:2] == 2'd1) ? RSRC_IN : RSRC_NONE;
          2'd1:    rd_src = RSRC_OUT;
          2'd2:    rd_src = RSRC_OE;
          default: rd_src = RSRC_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_fast_alias_reg.sv
module gpio_fast_alias_reg
  import gpio_fast_pkg::*;
#(
  parameter int unsigned WIDTH = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  output logic [WIDTH-1:0]  q
);

  logic [DATA_W-1:0] next_full;
  logic [WIDTH-1:0]  mask;
  logic [DATA_W-WIDTH-1:0] unused_hi;

  assign mask      = wdata[WIDTH-1:0];
  assign unused_hi = next_full[DATA_W-1:WIDTH] ^ wdata[DATA_W-1:WIDTH];
  assign next_full = alias_next(DATA_W'(q), wdata, op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= next_full[WIDTH-1:0];
  end

  AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == ALIAS_SET) |=> ((q & $past(mask)) == $past(mask))); // R3

  AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == ALIAS_CLR) |=> ((q & $past(mask)) == '0)); // R4

  AST_XOR_FLIPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == ALIAS_XOR) |=> ((q ^ $past(q)) == $past(mask))); // R5

  AST_ALIAS_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op != ALIAS_WRITE) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R6

endmodule

// File: rtl/gpio_fast_ctrl_bank.sv
module gpio_fast_ctrl_bank
  import gpio_fast_pkg::*;
#(
  parameter int unsigned NPINS = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-4:0]       pin_idx,
  input  logic [FSEL_W-1:0]       wsel,
  output logic [FSEL_W-1:0]       rsel,
  output logic [NPINS*FSEL_W-1:0] fsel_flat
);

  localparam int unsigned IDX_W = $clog2(NPINS);

  logic [FSEL_W-1:0] fsel_q [NPINS];

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          fsel_q[p] <= FSEL_W'(FSEL_RESET);
        else if (wr_en && pin_idx == (ADDR_W-3)'(p))
          fsel_q[p] <= wsel;
      end
      assign fsel_flat[p*FSEL_W +: FSEL_W] = fsel_q[p];
    end
  endgenerate

  assign rsel = (pin_idx < (ADDR_W-3)'(NPINS)) ? fsel_q[pin_idx[IDX_W-1:0]] : '0;

endmodule

// File: rtl/gpio_fast_pad_mux.sv
module gpio_fast_pad_mux
  import gpio_fast_pkg::*;
#(
  parameter int unsigned NPINS = 30
) (
  input  logic [NPINS*FSEL_W-1:0] fsel_flat,
  input  logic [NPINS-1:0]        reg_out,
  input  logic [NPINS-1:0]        reg_oe,
  input  logic [NPINS-1:0]        alt_out,
  input  logic [NPINS-1:0]        alt_oe,
  output logic [NPINS-1:0]        pad_out,
  output logic [NPINS-1:0]        pad_oe,
  output logic [NPINS-1:0]        fast_owned
);

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign fast_owned[p] = (fsel_flat[p*FSEL_W +: FSEL_W] == FSEL_W'(FSEL_FAST));
      assign pad_out[p]    = fast_owned[p] ? reg_out[p] : alt_out[p];
      assign pad_oe[p]     = fast_owned[p] ? reg_oe[p]  : alt_oe[p];
    end
  endgenerate

endmodule

// File: rtl/gpio_fast_io.sv
module gpio_fast_io
  import gpio_fast_pkg::*;
#(
  parameter int unsigned NPINS       = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  localparam int unsigned PAD_W = DATA_W - NPINS;

  logic                    out_wr;
  logic                    oe_wr;
  alias_op_e               op;
  logic                    ctrl_wr;
  rd_src_e                 rd_src;
  logic [ADDR_W-4:0]       pin_idx;
  logic [NPINS-1:0]        in_sync;
  logic [NPINS-1:0]        out_q;
  logic [NPINS-1:0]        oe_q;
  logic [FSEL_W-1:0]       ctrl_rsel;
  logic [NPINS*FSEL_W-1:0] fsel_flat;
  logic [NPINS-1:0]        fast_owned;
  logic [DATA_W-FSEL_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = bus_wdata[DATA_W-1:FSEL_W] & {(DATA_W-FSEL_W){ctrl_wr}};

  gpio_fast_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
  );

  gpio_fast_decode #(.NPINS(NPINS)) u_decode (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .out_wr(out_wr), .oe_wr(oe_wr), .op(op), .ctrl_wr(ctrl_wr),
    .rd_src(rd_src), .pin_idx(pin_idx)
  );

  gpio_fast_alias_reg #(.WIDTH(NPINS)) u_out_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(out_wr), .op(op),
    .wdata(bus_wdata), .q(out_q)
  );

  gpio_fast_alias_reg #(.WIDTH(NPINS)) u_oe_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(oe_wr), .op(op),
    .wdata(bus_wdata), .q(oe_q)
  );

  gpio_fast_ctrl_bank #(.NPINS(NPINS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .pin_idx(pin_idx),
    .wsel(bus_wdata[FSEL_W-1:0]), .rsel(ctrl_rsel), .fsel_flat(fsel_flat)
  );

  gpio_fast_pad_mux #(.NPINS(NPINS)) u_mux (
    .fsel_flat(fsel_flat), .reg_out(out_q), .reg_oe(oe_q),
    .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .fast_owned(fast_owned)
  );

  always_comb begin
    case (rd_src)
      RSRC_IN:   bus_rdata = {{PAD_W{1'b0}}, in_sync};
      RSRC_OUT:  bus_rdata = {{PAD_W{1'b0}}, out_q};
      RSRC_OE:   bus_rdata = {{PAD_W{1'b0}}, oe_q};
      RSRC_CTRL: bus_rdata = {{(DATA_W-FSEL_W){1'b0}}, ctrl_rsel};
      default:   bus_rdata = '0;
    endcase
  end

  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NPINS] == '0); // R2

  AST_OWNED_PAD_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && op == ALIAS_SET && $stable(fast_owned)) |=>
      ((pad_out & fast_owned & $past(bus_wdata[NPINS-1:0])) ==
       (fast_owned & $past(bus_wdata[NPINS-1:0])))); // R10

  AST_FOREIGN_PAD_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~fast_owned) == (alt_oe & ~fast_owned))); // R9

endmodule

// File: tb/gpio_fast_io_test.sv
`timescale 1ns/1ps
module gpio_fast_io_test;

  localparam int NP = 30;
  localparam logic [31:0] PMASK = 32'h3FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] alt_out = 30'h2AAA_AAAA;
  logic [NP-1:0] alt_oe  = 30'h1555_5555;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb [$];

  logic [31:0] m_out = '0;
  logic [31:0] m_oe  = '0;
  logic [4:0]  m_fs [NP];

  always #2 clk = ~clk;

  gpio_fast_io uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Monitor: pops the expected item for each read cycle
  always @(posedge clk) begin
    if (bus_sel && !bus_wr) begin
      rd_item_t it;
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty: act=%h exp=<none>", bus_rdata);
      end else begin
        it = sb.pop_front();
        total++;
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: act=%h exp=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] apply_op(logic [31:0] cur, logic [31:0] wd, int kind);
    logic [31:0] r;
    if (kind == 1)      r = cur | wd;
    else if (kind == 2) r = cur & ~wd;
    else if (kind == 3) r = cur ^ wd;
    else                r = wd;
    return r & PMASK;
  endfunction

  function automatic logic [NP-1:0] exp_pad(bit want_oe);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      if (m_fs[p] == 5'd5) r[p] = want_oe ? m_oe[p] : m_out[p];
      else                 r[p] = want_oe ? alt_oe[p] : alt_out[p];
    end
    return r;
  endfunction

  // All tasks start and end just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic fast_op(input bit oe_grp, input int kind, input logic [31:0] d, input string tag);
    logic [11:0] a;
    a = (oe_grp ? 12'h020 : 12'h010) + 12'(kind * 4);
    wr(a, d);
    if (oe_grp) m_oe  = apply_op(m_oe, d, kind);
    else        m_out = apply_op(m_out, d, kind);
    rd(oe_grp ? 12'h020 : 12'h010, oe_grp ? m_oe : m_out, tag);
  endtask

  task automatic chk_pads(input string tag);
    total++;
    if (pad_out !== exp_pad(1'b0)) begin
      bad++;
      $display("FAIL %s pad_out: act=%h exp=%h", tag, pad_out, exp_pad(1'b0));
    end
    total++;
    if (pad_oe !== exp_pad(1'b1)) begin
      bad++;
      $display("FAIL %s pad_oe: act=%h exp=%h", tag, pad_oe, exp_pad(1'b1));
    end
  endtask

  task automatic set_fs(input int pin, input logic [31:0] d);
    wr(12'h800 + 12'(pin * 8 + 4), d);
    if (pin < NP) m_fs[pin] = d[4:0];
  endtask

  initial begin
    for (int p = 0; p < NP; p++) m_fs[p] = 5'd31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h010, 32'h0, "R1 out reset");
    rd(12'h020, 32'h0, "R1 oe reset");
    rd(12'h804, 32'h1F, "R1 fsel pin0 reset");
    rd(12'h8EC, 32'h1F, "R1 fsel pin29 reset");
    chk_pads("R1 pads alt after reset");

    // R2 plain writes, top bits
    fast_op(1'b0, 0, 32'hFFFF_FFFF, "R2 out all ones");
    fast_op(1'b1, 0, 32'h1234_5678, "R2 oe replace");
    fast_op(1'b0, 0, 32'h0F0F_0F0F, "R2 out replace");

    // R3/R4/R5 alias updates on both registers
    fast_op(1'b0, 1, 32'hFF00_00F0, "R3 out set");
    fast_op(1'b1, 1, 32'h0000_FFFF, "R3 oe set");
    fast_op(1'b0, 2, 32'h0000_FF0F, "R4 out clr");
    fast_op(1'b1, 2, 32'hC30F_00F0, "R4 oe clr");
    fast_op(1'b0, 3, 32'hFFFF_0000, "R5 out xor");
    fast_op(1'b1, 3, 32'h3C3C_3C3C, "R5 oe xor");

    // R6 alias reads and unmapped offsets
    rd(12'h014, m_out, "R6 out set alias read");
    rd(12'h018, m_out, "R6 out clr alias read");
    rd(12'h01C, m_out, "R6 out xor alias read");
    rd(12'h028, m_oe,  "R6 oe clr alias read");
    rd(12'h008, 32'h0, "R6 unmapped 0x08 read");
    rd(12'h030, 32'h0, "R6 unmapped 0x30 read");
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h010, m_out, "R6 out after unmapped write");
    rd(12'h020, m_oe,  "R6 oe after unmapped write");

    // R8 control words
    set_fs(25, 32'hFFFF_FFE5);
    rd(12'h8CC, 32'h5, "R8 pin25 fsel readback");
    rd(12'h8C8, 32'h0, "R8 pin25 first word");
    wr(12'h8C8, 32'h5);
    rd(12'h8CC, 32'h5, "R8 first-word write ignored");
    wr(12'h8F4, 32'h5);
    rd(12'h8F4, 32'h0, "R8 pin30 read zero");
    rd(12'h804, 32'h1F, "R8 pin0 untouched");
    set_fs(3, 32'h5);
    set_fs(4, 32'h2);

    // R9 ownership per pin
    chk_pads("R9 mixed owners");
    m_out = 32'h0; wr(12'h010, 32'h0);
    m_oe = 32'h0;  wr(12'h020, 32'h0);
    chk_pads("R9 owned pins zero");
    alt_out = ~alt_out; alt_oe = ~alt_oe;
    #0.1;
    chk_pads("R9 alt pattern swapped");

    // R10 pad changes one edge after write
    wr(12'h014, 32'h0200_0008);
    m_out = apply_op(m_out, 32'h0200_0008, 1);
    chk_pads("R10 set pins 25 and 3");
    wr(12'h024, 32'h0200_0000);
    m_oe = apply_op(m_oe, 32'h0200_0000, 1);
    chk_pads("R10 oe pin25");
    wr(12'h01C, 32'h0200_0010);
    m_out = apply_op(m_out, 32'h0200_0010, 3);
    chk_pads("R10 xor pin25 and pin4 foreign");
    set_fs(25, 32'h1);
    chk_pads("R9 pin25 released");

    // R7 synchroniser timing
    pad_in = 30'h2345_6789;
    rd(12'h004, 32'h0, "R7 before edge one");
    rd(12'h004, 32'h0, "R7 after one edge");
    rd(12'h004, 32'h2345_6789, "R7 after two edges");
    pad_in = 30'h3FFF_FFFF;
    @(negedge clk); @(negedge clk);
    rd(12'h004, 32'h3FFF_FFFF, "R7 all ones top bits zero");

    @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover: act=%0d exp=0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule